// File: doc/BRIEF.md
# Accumulator Add Instruction Executor

This block is an 8-bit execution slice that runs two add instructions against a working register and a banked byte memory. The first adds an 8-bit literal carried in the instruction word to the working register. The second adds the working register to a byte in data memory. A destination bit sends the sum either to the working register or back to that memory byte. A bank bit picks how the 8-bit file address in the instruction becomes a full memory address. It can map directly into a fixed access window, or it can be extended by a bank select register.

Each instruction takes one instruction cycle. That cycle is split into four phases, driven by a free-running phase counter: Q1 accept and decode, Q2 read the operand, Q3 compute the sum and flags, Q4 write back. An upstream fetch stage presents an instruction word with a valid strobe in Q1. The block answers with a one-cycle done pulse once the write-back is finished. The bank select register is loaded through a dedicated strobe. The working register, bank select register and flags are always visible on output ports. A second memory port lets a debugger read any byte.

Top module: `acc_add_exec`

## Requirements
- R1: A synchronous active-high reset sets the phase to Q1. It clears the working register, the bank select register and all flags, and drives done low. The data memory keeps its contents.
- R2: The phase counter steps Q1, Q2, Q3, Q4, Q1 on every clock. An instruction is accepted only on a clock edge in Q1 with instr_valid high. A valid strobe in Q2 to Q4 is ignored: nothing changes and no done follows.
- R3: A word whose upper byte is 0x0F is a literal add. The working register becomes the working register plus the lower byte, modulo 256.
- R4: A word whose upper six bits are 001001 is a register add. Bit 9 is the destination and bit 8 is the bank bit. With bit 9 at 0 the sum is written to the working register and the memory byte is unchanged. With bit 9 at 1 the sum is written to the memory byte and the working register is unchanged.
- R5: With the bank bit at 0, file address f maps as follows: f below 0x80 goes to memory address f, and f at or above 0x80 goes to the top 128 bytes of memory. With the default size, that is 0xF80 + (f - 0x80).
- R6: With the bank bit at 1, the memory address is the bank select register value concatenated above f. A clock edge with bsr_load high loads bsr_value into the bank select register.
- R7: Both instructions set flags_o as follows: bit 0 is carry out of bit 7, bit 1 is carry out of bit 3, bit 2 is result equal to zero, bit 3 is signed overflow, and bit 4 is bit 7 of the result.
- R8: A word that matches neither pattern changes no register, flag or memory byte, but done still pulses.
- R9: done is high for exactly one cycle: the cycle after the Q4 edge of an accepted instruction. Register outputs and memory already show the results in that cycle.
- R10: The data memory holds zeros at start-up. dbg_rdata shows the byte at dbg_addr one clock after dbg_addr is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is present (sampled in Q1) |
| instr_word | input | 16 | Instruction word |
| bsr_load | input | 1 | Load strobe for the bank select register |
| bsr_value | input | BSR_W | Value loaded into the bank select register |
| dbg_addr | input | BSR_W+8 | Debug memory read address |
| done | output | 1 | One-cycle completion pulse |
| wreg_o | output | 8 | Working register |
| bsr_o | output | BSR_W | Bank select register |
| flags_o | output | 5 | Flags {N, OV, Z, DC, C} |
| dbg_rdata | output | 8 | Debug memory read data |

## Verification
The bench uses the default BSR_W of 4, which gives a 4096-byte memory. This places the upper half of the access window at 0xF80 to 0xFFF. With that map, a bank select value of 0xF aliases the same bytes as direct access. The bench checks this alias: it writes byte 0xF85 with the bank bit at 0, then reads it back with the bank bit at 1. It also shows that neighbouring addresses such as 0x085 and 0x010 stay untouched, so a mapping that drops or swaps address bits becomes visible.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int DW = 8;
  localparam int IW = 16;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LIT  = 2'd1,
    OP_REG  = 2'd2
  } op_kind_e;

  typedef struct packed {
    logic n;
    logic ov;
    logic z;
    logic dc;
    logic c;
  } flags_t;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
#(
  parameter int BSR_W = 4,
  localparam int AW = BSR_W + DW
) (
  input  logic [IW-1:0]    ir,
  input  logic [BSR_W-1:0] bsr,
  output op_kind_e         kind,
  output logic [DW-1:0]    lit,
  output logic             to_file,
  output logic [AW-1:0]    addr
);
  logic [DW-1:0] fadr;
  logic          use_bank;

  assign fadr     = ir[DW-1:0];
  assign lit      = ir[DW-1:0];
  assign to_file  = ir[9];
  assign use_bank = ir[8];

  always_comb begin
    if (ir[15:8] == 8'h0F)          kind = OP_LIT;
    else if (ir[15:10] == 6'b001001) kind = OP_REG;
    else                             kind = OP_NONE;
  end

  // access window: low half at the bottom, high half at the top of memory
  assign addr = use_bank ? {bsr, fadr} : {{BSR_W{fadr[DW-1]}}, fadr};
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] sum,
  output flags_t        fl
);
  logic [DW:0] wide;
  logic [4:0]  low;

  assign wide  = {1'b0, a} + {1'b0, b};
  assign low   = {1'b0, a[3:0]} + {1'b0, b[3:0]};
  assign sum   = wide[DW-1:0];
  assign fl.c  = wide[DW];
  assign fl.dc = low[4];
  assign fl.z  = (wide[DW-1:0] == '0);
  assign fl.n  = wide[DW-1];
  assign fl.ov = (a[DW-1] == b[DW-1]) && (wide[DW-1] != a[DW-1]);
endmodule

// File: rtl/acc_bram.sv
module acc_bram #(
  parameter int AW = 12,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic [AW-1:0] a_addr,
  input  logic          a_we,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);
  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/acc_add_exec.sv
module acc_add_exec
  import acc_pkg::*;
#(
  parameter int BSR_W = 4,
  localparam int AW = BSR_W + DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instr_valid,
  input  logic [IW-1:0]    instr_word,
  input  logic             bsr_load,
  input  logic [BSR_W-1:0] bsr_value,
  input  logic [AW-1:0]    dbg_addr,
  output logic             done,
  output logic [DW-1:0]    wreg_o,
  output logic [BSR_W-1:0] bsr_o,
  output logic [4:0]       flags_o,
  output logic [DW-1:0]    dbg_rdata
);
  localparam logic [1:0] PH_Q1 = 2'd0;
  localparam logic [1:0] PH_Q3 = 2'd2;
  localparam logic [1:0] PH_Q4 = 2'd3;

  logic [1:0]       phase_q;
  logic             act_q;
  logic [IW-1:0]    ir_q;
  logic [DW-1:0]    wreg_q;
  logic [BSR_W-1:0] bsr_q;
  flags_t           flags_q;
  logic             done_q;
  logic [DW-1:0]    sum_q;
  flags_t           fl_q;

  op_kind_e      kind;
  logic [DW-1:0] lit;
  logic          to_file;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] operand;
  logic [DW-1:0] alu_sum;
  flags_t        alu_fl;
  logic          mem_we;

  acc_decode #(.BSR_W(BSR_W)) u_dec (
    .ir(ir_q), .bsr(bsr_q), .kind(kind), .lit(lit),
    .to_file(to_file), .addr(mem_addr)
  );

  assign operand = (kind == OP_LIT) ? lit : mem_rdata;

  acc_alu u_alu (.a(wreg_q), .b(operand), .sum(alu_sum), .fl(alu_fl));

  assign mem_we = (phase_q == PH_Q4) && act_q && (kind == OP_REG) && to_file;

  acc_bram #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .a_addr(mem_addr), .a_we(mem_we), .a_wdata(sum_q),
    .a_rdata(mem_rdata), .b_addr(dbg_addr), .b_rdata(dbg_rdata)
  );

  // phase counter and instruction capture
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_Q1;
      act_q   <= 1'b0;
      ir_q    <= '0;
    end else begin
      phase_q <= phase_q + 2'd1;
      if (phase_q == PH_Q1) begin
        act_q <= instr_valid;
        if (instr_valid) ir_q <= instr_word;
      end
    end
  end

  // Q3: register the sum and flags (memory operand arrived after Q2)
  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
      fl_q  <= '0;
    end else if (phase_q == PH_Q3) begin
      sum_q <= alu_sum;
      fl_q  <= alu_fl;
    end
  end

  // Q4: write back
  always_ff @(posedge clk) begin
    if (rst) begin
      wreg_q  <= '0;
      flags_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (phase_q == PH_Q4) && act_q;
      if ((phase_q == PH_Q4) && act_q && (kind != OP_NONE)) begin
        flags_q <= fl_q;
        if (!((kind == OP_REG) && to_file)) wreg_q <= sum_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           bsr_q <= '0;
    else if (bsr_load) bsr_q <= bsr_value;
  end

  assign done    = done_q;
  assign wreg_o  = wreg_q;
  assign bsr_o   = bsr_q;
  assign flags_o = flags_q;

  assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_Q4) |=> (phase_q == PH_Q1));

  assert_w_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_Q4) |=> $stable(wreg_o));

  assert_file_dest_keeps_w_R4: assert property (@(posedge clk) disable iff (rst)
    ((phase_q == PH_Q4) && act_q && (kind == OP_REG) && to_file) |=> $stable(wreg_o));

  assert_unknown_hold_R8: assert property (@(posedge clk) disable iff (rst)
    ((phase_q == PH_Q4) && act_q && (kind == OP_NONE)) |=>
      ($stable(wreg_o) && $stable(flags_o)));

  assert_done_in_q1_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (phase_q == PH_Q1));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/acc_add_exec_bench.sv
`timescale 1ns/1ps
module acc_add_exec_bench;
  localparam int BSR_W = 4;
  localparam int AW = BSR_W + 8;

  logic             clk = 1'b0;
  logic             rst = 1'b0;
  logic             instr_valid = 1'b0;
  logic [15:0]      instr_word = '0;
  logic             bsr_load = 1'b0;
  logic [BSR_W-1:0] bsr_value = '0;
  logic [AW-1:0]    dbg_addr = '0;
  logic             done;
  logic [7:0]       wreg_o;
  logic [BSR_W-1:0] bsr_o;
  logic [4:0]       flags_o;
  logic [7:0]       dbg_rdata;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  acc_add_exec #(.BSR_W(BSR_W)) u_acc_add_exec (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .bsr_load(bsr_load), .bsr_value(bsr_value), .dbg_addr(dbg_addr),
    .done(done), .wreg_o(wreg_o), .bsr_o(bsr_o), .flags_o(flags_o),
    .dbg_rdata(dbg_rdata)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // every task starts and ends at a falling edge inside phase Q1
  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic exec(input logic [15:0] w);
    instr_word = w; instr_valid = 1'b1;
    @(posedge clk);
    @(negedge clk); instr_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 done after Q4", done, 1);
  endtask

  task automatic load_bsr(input logic [BSR_W-1:0] v);
    bsr_value = v; bsr_load = 1'b1;
    @(posedge clk);
    @(negedge clk); bsr_load = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6 bank select load", bsr_o, v);
  endtask

  task automatic peek(input logic [AW-1:0] a, input int exp, input string req);
    dbg_addr = a;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(req, dbg_rdata, exp);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 wreg cleared", wreg_o, 0);
    check("R1 bsr cleared", bsr_o, 0);
    check("R1 flags cleared", flags_o, 0);
    check("R1 done low", done, 0);
  endtask

  task automatic t_literal();
    exec(16'h0F10);
    exec(16'h0F15);
    check("R3 literal sum", wreg_o, 8'h25);
    check("R7 flags clear", flags_o, 5'h00);
    exec(16'h0FDB);
    check("R3 wrap to zero", wreg_o, 8'h00);
    check("R7 carry digit zero", flags_o, 5'h07);
    exec(16'h0F7F);
    exec(16'h0F01);
    check("R3 sum 0x80", wreg_o, 8'h80);
    check("R7 neg ovf digit", flags_o, 5'h1A);
  endtask

  task automatic t_register();
    do_reset();
    exec(16'h0FC2);
    exec(16'h2620);
    check("R4 file dest keeps wreg", wreg_o, 8'hC2);
    check("R7 flags file dest", flags_o, 5'h10);
    peek(12'h020, 8'hC2, "R4 file byte written");
    do_reset();
    exec(16'h0F17);
    exec(16'h2420);
    check("R4 wreg dest sum", wreg_o, 8'hD9);
    check("R7 flags 0x17+0xC2", flags_o, 5'h10);
    peek(12'h020, 8'hC2, "R4 file byte unchanged");
  endtask

  task automatic t_access_window();
    exec(16'h2685);
    peek(12'hF85, 8'hD9, "R5 upper access window");
    peek(12'h085, 8'h00, "R5 low address untouched");
  endtask

  task automatic t_banked();
    load_bsr(4'h3);
    exec(16'h2710);
    check("R4 wreg kept banked write", wreg_o, 8'hD9);
    peek(12'h310, 8'hD9, "R6 banked write address");
    peek(12'h010, 8'h00, "R6 bank0 untouched");
    load_bsr(4'hF);
    exec(16'h2585);
    check("R6 banked read alias", wreg_o, 8'hB2);
    check("R7 carry digit neg", flags_o, 5'h13);
  endtask

  task automatic t_unknown();
    exec(16'h0E12);
    check("R8 wreg unchanged", wreg_o, 8'hB2);
    check("R8 flags unchanged", flags_o, 5'h13);
    exec(16'h2885);
    check("R8 wreg unchanged 2", wreg_o, 8'hB2);
    peek(12'hF85, 8'hD9, "R8 memory unchanged");
  endtask

  task automatic t_off_phase();
    @(posedge clk);
    @(negedge clk); instr_word = 16'h0F01; instr_valid = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); instr_valid = 1'b0;
    check("R2 no done off phase", done, 0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R2 off phase ignored", wreg_o, 8'hB2);
    check("R9 no stray done", done, 0);
  endtask

  task automatic t_mem_init();
    peek(12'hABC, 8'h00, "R10 memory starts zero");
  endtask

  initial begin
    t_reset();
    t_literal();
    t_register();
    t_access_window();
    t_banked();
    t_unknown();
    t_off_phase();
    t_mem_init();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule